// File: doc/BRIEF.md
# EEPROM Block Write-Protect Controller

This block holds an 8-bit protection register and decides, request by request, whether a program, row-erase or bulk-erase operation may go to an on-chip EEPROM array or to its configuration register. After reset every protection is on. Software lifts protection by writing zeros into the register. In normal mode this works only once, and only within a short window of clock cycles after reset. After that, writes can only add protection, and the added protection holds until the next reset. In special mode the register can be reloaded freely, and configuration protection does not apply.

The array occupies offsets 0xD00 to 0xFFF of a 12-bit offset space and is split into five blocks of unequal size. Each request presents an operation code, a target flag (array or configuration register) and the 12-bit offset. The block answers in the same cycle with a grant and a flag that marks offsets lying below the array. The charge pump, the cell timing and the decoding of bus addresses other than the register write strobe are handled outside this block.

Top module: `ee_guard`

## Requirements
- R1: Out of reset the register reads 0xBF. Bit 6 always reads 0, whatever is written to it. Bit 7 is bulk protect. Bit 5 protects block 4. Bit 4 protects the configuration register. Bits 3..0 protect blocks 3..0.
- R2: In normal mode, the first register write taken at one of the clock edges numbered 0..63 loads the written value, so it can clear bits. Edge 0 is the first rising edge after reset is released. A write at edge 64 or later cannot clear any bit.
- R3: In normal mode, every write after that first in-window write, and every write after the window has closed, stores the old value OR the written data.
- R4: In special mode, every write loads the written value (bit 6 forced to 0) at any time. Such writes do not use up the normal-mode clear.
- R5: Array offsets map to blocks as follows: block 0 is 0xD00–0xD1F, block 1 is 0xD20–0xD5F, block 2 is 0xD60–0xDDF, block 3 is 0xDE0–0xEFF, block 4 is 0xF00–0xFFF. Every offset falls either below 0xD00 or in exactly one block.
- R6: When the array is targeted (req_cfg=0) and the offset is below 0xD00, not_array is 1 and program and row erase are refused. In all other cases not_array is 0.
- R7: An array program (op 00) is granted exactly when the block holding the offset has its protect bit at 0.
- R8: An array row erase (op 01) is granted exactly when bulk protect is 0 and the block holding the offset has its protect bit at 0.
- R9: An array bulk erase (op 10) is granted exactly when bulk protect and all five block bits are 0. The offset is not considered.
- R10: A request with req_cfg=1 and op 00, 01 or 10 is granted exactly when special mode is on or configuration protect is 0.
- R11: Op 11 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| reg_wr | input | 1 | Write strobe for the protection register |
| reg_wdata | input | 8 | Data written to the protection register |
| reg_rdata | output | 8 | Current contents of the protection register |
| req_op | input | 2 | 00 program, 01 row erase, 10 bulk erase, 11 reserved |
| req_cfg | input | 1 | 1 = configuration register target, 0 = array target |
| req_off | input | 12 | Offset of the request within the 4 KiB window |
| req_grant | output | 1 | 1 when the request may proceed |
| req_not_array | output | 1 | Array target with an offset below 0xD00 |

## Verification
The grant logic is driven through all 128 settings of the seven implemented register bits. For each setting it sees every operation code, both targets and both modes, at the first and last offset of each block plus points below the array and inside blocks. This separates off-by-one range errors from errors in the bit-to-block mapping, and it separates the bulk-erase and row-erase rules from each other. A full sweep of all 4096 offsets with a mixed protection pattern then confirms the block decode everywhere. The register sequences write at edges 63 and 64, write twice inside the window, and reload freely in special mode. Together they tell the window bound, the once-only clear and the OR behaviour apart.

// File: rtl/ee_guard_pkg.sv
`timescale 1ns/1ps
package ee_guard_pkg;

    localparam int NBLK    = 5;
    localparam int OFF_W   = 12;
    localparam int REG_W   = 8;
    localparam int ARRAY_LO = 'hD00;

    localparam int BIT_BULK = 7;
    localparam int BIT_NONE = 6;
    localparam int BIT_CFG  = 4;

    localparam logic [REG_W-1:0] RESET_VAL = 8'hBF;
    localparam logic [REG_W-1:0] REG_MASK  = ~(REG_W'(1) << BIT_NONE);

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_ROW  = 2'b01,
        OP_BULK = 2'b10,
        OP_RSVD = 2'b11
    } ee_op_e;

    typedef struct packed {
        logic [REG_W-1:0] prot;
        logic             clr_used;
    } prot_state_t;

    function automatic int blk_size(int i);
        case (i)
            0:       return 32;
            1:       return 64;
            2:       return 128;
            3:       return 288;
            default: return 256;
        endcase
    endfunction

    function automatic int blk_lo(int i);
        int s;
        s = ARRAY_LO;
        for (int k = 0; k < i; k++) s += blk_size(k);
        return s;
    endfunction

    function automatic int blk_bit(int i);
        return (i == 4) ? 5 : i;
    endfunction

endpackage

// File: rtl/ee_guard_window.sv
`timescale 1ns/1ps
module ee_guard_window #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_open
);
    localparam int CW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt < CW'(WINDOW)) st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_open = (st_q.cnt < CW'(WINDOW));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(WINDOW));

    // R2
    win_stays_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_open) |-> !win_open);

endmodule

// File: rtl/ee_guard_reg.sv
`timescale 1ns/1ps
module ee_guard_reg
    import ee_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             win_open,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] prot
);
    prot_state_t st_d, st_q;
    logic        clear_ok;
    logic [REG_W-1:0] wmask;

    always_comb begin
        st_d     = st_q;
        wmask    = wr_data & REG_MASK;
        clear_ok = special_mode | (win_open & ~st_q.clr_used);
        if (wr_en) begin
            if (clear_ok) st_d.prot = wmask;
            else          st_d.prot = st_q.prot | wmask;
            if (!special_mode && win_open) st_d.clr_used = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prot     <= RESET_VAL;
            st_q.clr_used <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot = st_q.prot;

    // R3
    bits_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_ok) |-> ((st_q.prot & $past(st_q.prot)) == $past(st_q.prot)));

    // R2
    clear_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.clr_used) |-> $past(win_open));

    // R1
    unused_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prot[BIT_NONE] == 1'b0);

endmodule

// File: rtl/ee_guard_decode.sv
`timescale 1ns/1ps
module ee_guard_decode
    import ee_guard_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output logic [NBLK-1:0]  hit,
    output logic             below
);
    logic [OFF_W:0] off_x;
    assign off_x = {1'b0, off};
    assign below = (off_x < (OFF_W+1)'(ARRAY_LO));

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        localparam logic [OFF_W:0] LO = (OFF_W+1)'(blk_lo(i));
        localparam logic [OFF_W:0] HI = (OFF_W+1)'(blk_lo(i) + blk_size(i));
        assign hit[i] = (off_x >= LO) && (off_x < HI);
    end

    always_comb begin
        // R5
        blk_onehot_chk: assert ($onehot0(hit));
        // R5
        blk_cover_chk: assert (below ^ (|hit));
    end

endmodule

// File: rtl/ee_guard.sv
`timescale 1ns/1ps
module ee_guard
    import ee_guard_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [1:0]       req_op,
    input  logic             req_cfg,
    input  logic [11:0]      req_off,
    output logic             req_grant,
    output logic             req_not_array
);
    logic             win_open;
    logic [REG_W-1:0] prot;
    logic [NBLK-1:0]  hit;
    logic [NBLK-1:0]  blk_prot;
    logic             below;
    logic             any_open;
    logic             all_clear;
    logic             bulk_prot;
    ee_op_e           op;

    ee_guard_window #(.WINDOW(WINDOW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_open (win_open)
    );

    ee_guard_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .win_open     (win_open),
        .wr_en        (reg_wr),
        .wr_data      (reg_wdata),
        .prot         (prot)
    );

    ee_guard_decode u_dec (
        .off   (req_off),
        .hit   (hit),
        .below (below)
    );

    for (genvar i = 0; i < NBLK; i++) begin : g_map
        assign blk_prot[i] = prot[blk_bit(i)];
    end

    assign op        = ee_op_e'(req_op);
    assign bulk_prot = prot[BIT_BULK];
    assign any_open  = |(hit & ~blk_prot);
    assign all_clear = ~|blk_prot;

    always_comb begin
        req_grant = 1'b0;
        if (req_cfg) begin
            req_grant = (op != OP_RSVD) && (special_mode || !prot[BIT_CFG]);
        end else begin
            case (op)
                OP_PROG: req_grant = !below && any_open;
                OP_ROW:  req_grant = !below && any_open && !bulk_prot;
                OP_BULK: req_grant = !bulk_prot && all_clear;
                default: req_grant = 1'b0;
            endcase
        end
    end

    assign req_not_array = !req_cfg && below;
    assign reg_rdata     = prot;

    // R6
    below_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_not_array && req_op != 2'b10) |-> !req_grant);

    // R9
    bulk_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && !req_cfg && req_op == 2'b10) |-> ((reg_rdata & 8'hAF) == 8'h00));

    // R10
    cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && req_cfg && !special_mode) |-> !reg_rdata[4]);

    // R11
    rsvd_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 2'b11) |-> !req_grant);

endmodule

// File: tb/sim_ee_guard.sv
`timescale 1ns/1ps
module sim_ee_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [1:0]  req_op = 2'b00;
    logic        req_cfg = 1'b0;
    logic [11:0] req_off = 12'h000;
    logic        req_grant;
    logic        req_not_array;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ee_guard u0 (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_op(req_op), .req_cfg(req_cfg), .req_off(req_off),
        .req_grant(req_grant), .req_not_array(req_not_array)
    );

    task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_reset(bit sp);
        special_mode = sp;
        reg_wr = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic int blk_of(logic [11:0] o);
        if (o < 12'hD00) return -1;
        if (o < 12'hD20) return 0;
        if (o < 12'hD60) return 1;
        if (o < 12'hDE0) return 2;
        if (o < 12'hF00) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] pat_to_reg(int p);
        logic [7:0] r;
        r = 8'h00;
        r[7] = p[6];
        r[5] = p[5];
        r[4] = p[4];
        r[3:0] = p[3:0];
        return r;
    endfunction

    task automatic chk_req(logic [7:0] r, logic [1:0] op, bit cfg, logic [11:0] off, bit sp);
        int  b;
        bit  bp, eg, ena;
        string tag;
        req_op = op; req_cfg = cfg; req_off = off; special_mode = sp;
        #1;
        b = blk_of(off);
        bp = (b < 0) ? 1'b1 : ((b == 4) ? r[5] : r[b]);
        ena = !cfg && (b < 0);
        if (op == 2'b11) begin
            eg = 1'b0; tag = "R11";
        end else if (cfg) begin
            eg = sp || !r[4]; tag = "R10";
        end else if (op == 2'b00) begin
            eg = (b >= 0) && !bp; tag = (b < 0) ? "R6" : "R7/R5";
        end else if (op == 2'b01) begin
            eg = (b >= 0) && !bp && !r[7]; tag = (b < 0) ? "R6" : "R8/R5";
        end else begin
            eg = !r[7] && ((r & 8'hAF) == 8'h00); tag = "R9";
        end
        total++;
        if (req_grant !== eg || req_not_array !== ena) begin
            fails++;
            $display("FAIL %s: reg=%02h op=%0d cfg=%0d off=%03h sp=%0d got g=%0b na=%0b expected g=%0b na=%0b",
                     tag, r, op, cfg, off, sp, req_grant, req_not_array, eg, ena);
        end
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] pts [14];
        pts = '{12'h000, 12'hCFF, 12'hD00, 12'hD1F, 12'hD20, 12'hD5F, 12'hD60,
                12'hDDF, 12'hDE0, 12'hEFF, 12'hF00, 12'hFFF, 12'h7D5, 12'hE50};

        // R1: reset value
        do_reset(1'b0);
        #1;
        check8("R1 reset value", reg_rdata, 8'hBF);

        // R2: write at edge 63 clears; R3: then OR; R1: bit 6 ignored
        idle(63);
        wr(8'h00);
        check8("R2 clear at edge 63", reg_rdata, 8'h00);
        wr(8'h01);
        check8("R3 set after clear", reg_rdata, 8'h01);
        wr(8'h40);
        check8("R1 bit6 stays 0", reg_rdata, 8'h01);
        wr(8'h00);
        check8("R3 zero write no effect", reg_rdata, 8'h01);

        // R2: write at edge 64 cannot clear
        do_reset(1'b0);
        idle(64);
        wr(8'h00);
        check8("R2 late write", reg_rdata, 8'hBF);

        // R3: only one clear inside the window
        do_reset(1'b0);
        wr(8'h0A);
        check8("R2 clear at edge 0", reg_rdata, 8'h0A);
        wr(8'h00);
        check8("R3 second in-window write", reg_rdata, 8'h0A);
        wr(8'h20);
        check8("R3 OR on later write", reg_rdata, 8'h2A);

        // R4: special mode loads at any time and does not use up the clear
        do_reset(1'b1);
        idle(100);
        wr(8'h00);
        check8("R4 special clear late", reg_rdata, 8'h00);
        wr(8'hF5);
        check8("R4 special load", reg_rdata, 8'hB5);
        wr(8'h00);
        check8("R4 special reload", reg_rdata, 8'h00);
        do_reset(1'b1);
        wr(8'hFF);
        special_mode = 1'b0;
        wr(8'h12);
        check8("R4 clear still available", reg_rdata, 8'h12);

        // R5..R11: all register patterns against boundary offsets
        for (int p = 0; p < 128; p++) begin
            logic [7:0] r;
            r = pat_to_reg(p);
            special_mode = 1'b1;
            wr(r);
            check8("R4 pattern load", reg_rdata, r);
            for (int k = 0; k < 14; k++)
                for (int op = 0; op < 4; op++)
                    for (int c = 0; c < 2; c++)
                        for (int s = 0; s < 2; s++)
                            chk_req(r, 2'(op), c[0], pts[k], s[0]);
        end

        // R5: every offset, mixed pattern
        special_mode = 1'b1;
        wr(8'h15);
        for (int a = 0; a < 4096; a++) begin
            chk_req(8'h15, 2'b00, 1'b0, 12'(a), 1'b0);
            chk_req(8'h15, 2'b01, 1'b0, 12'(a), 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule